// File: doc/BRIEF.md
# Keyed-Restart Watchdog Timer

This block is a down-counting watchdog that sits on a small 32-bit register bus with an address, write and read strobes, and write and read data. Software loads a reload value, arms the counter through a control register, and keeps the system alive by writing a fixed key to a restart register before the count runs out. A write of any other value to that register is ignored, so a stray store cannot feed the dog.

When the count reaches zero the block reloads itself and records the expiry in a sticky status register. Depending on the control bits it also does the following:
- pulses one of three reset-request lines (SoC, full chip or CPU only);
- starts a programmable-width pulse on an external trigger output;
- latches an alternate-boot indication.

A pretimeout threshold in the upper control bits raises an early-warning interrupt before the count reaches zero. The counter steps either on every clock or only on cycles where an external 1 MHz tick-enable input is high. All status bits are cleared through a dedicated write-only clear register.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the bus reads return the following values: counter 0x0100_0000, reload 0x0100_0000, control 0, status 0, pulse width 0xFF. All interrupt, reset-request, external-pulse and boot outputs are low.
- R2: A write of exactly 0x0000_4755 to offset 0x08 loads the counter from the reload register (offset 0x04). Any other value written there leaves the counter unchanged.
- R3: While control bit 0 is set the counter decrements by one on each step. Control bit 4 set means a step happens only on cycles with tick_i high; clear means every clock is a step. With bit 0 clear the counter holds its value.
- R4: A step taken with the counter at zero reloads it from the reload register and sets status bit 0 (status at offset 0x10).
- R5: That expiry, when control bit 1 is set, drives exactly one reset-request output high for one cycle. The output is chosen by control bits 6:5: 00 and 11 select rst_soc_o, 01 selects rst_chip_o, 10 selects rst_cpu_o. With bit 1 clear no request is made.
- R6: When control bits 2 and 0 are both set and counter bits 31:10 equal control bits 31:10, status bit 2 sets and irq_o is raised. Both stay high until cleared. With bit 2 clear no interrupt occurs.
- R7: An expiry with control bit 7 set sets status bit 1. That bit, mirrored on boot_alt_o, stays set until cleared.
- R8: A write to offset 0x14 with data bit 0 set clears status bits 2:0. A write there with bit 0 clear has no effect. A status event in the same cycle as a clear wins.
- R9: An expiry with control bit 3 set drives ext_pulse_o high for (W+1) steps, where W is bits 19:0 of offset 0x18.
- R10: Reads are combinational while rd_i is high and return 0 when rd_i is low. Offsets 0x08, 0x14 and unmapped offsets read 0. Control bits 9:8 and pulse-width bits 31:20 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 MHz step enable, used when control bit 4 is set |
| addr_i | input | 8 | Register byte offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid in the cycle rd_i is high |
| irq_o | output | 1 | Pretimeout interrupt, level |
| rst_soc_o | output | 1 | SoC reset request, one-cycle pulse |
| rst_chip_o | output | 1 | Full-chip reset request, one-cycle pulse |
| rst_cpu_o | output | 1 | CPU-only reset request, one-cycle pulse |
| ext_pulse_o | output | 1 | External trigger pulse |
| boot_alt_o | output | 1 | Sticky alternate-boot indication |

## Verification
The bench targets the following corner cases:
- A near-miss restart value. A design that compared only part of the key would reload the counter on it.
- The exact cycle of the zero-count expiry. An off-by-one reload would move the reset pulse, lengthen it, or leave the wrong residual count.
- All four reset-scope encodings, including the 11 alias. A bad decode would fire the wrong line or two lines at once.
- The tick gate, the pretimeout threshold crossing, and the clear write with bit 0 low. Mistakes here show up as counting at clock rate, an interrupt one cycle early or late or not sticky, or status wiped by a write that should be ignored.
- An external pulse one step short or long, which reveals a miscounted width.

// File: rtl/keyed_wdt_pkg.sv
package keyed_wdt_pkg;
  localparam int DATA_W = 32;

  localparam logic [7:0] OFF_COUNT   = 8'h00;
  localparam logic [7:0] OFF_RELOAD  = 8'h04;
  localparam logic [7:0] OFF_RESTART = 8'h08;
  localparam logic [7:0] OFF_CTRL    = 8'h0C;
  localparam logic [7:0] OFF_STATUS  = 8'h10;
  localparam logic [7:0] OFF_CLEAR   = 8'h14;
  localparam logic [7:0] OFF_PWIDTH  = 8'h18;

  localparam int ST_TIMEOUT = 0;
  localparam int ST_BOOT    = 1;
  localparam int ST_PRE     = 2;
  localparam int ST_W       = 3;

  typedef enum logic [1:0] {
    SCOPE_SOC  = 2'b00,
    SCOPE_CHIP = 2'b01,
    SCOPE_CPU  = 2'b10,
    SCOPE_SOC2 = 2'b11
  } scope_e;

  // low control byte, bit 7 down to bit 0
  typedef struct packed {
    logic   boot_sel;
    scope_e scope;
    logic   use_tick;
    logic   ext_en;
    logic   irq_en;
    logic   rst_en;
    logic   en;
  } ctrl_lo_t;
endpackage

// File: rtl/keyed_wdt_regs.sv
module keyed_wdt_regs
  import keyed_wdt_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          CNT_W       = 32,
  parameter int          THR_LSB     = 10,
  parameter int          PW_W        = 20,
  parameter logic [31:0] RESTART_KEY = 32'h0000_4755,
  parameter logic [31:0] RELOAD_RST  = 32'h0100_0000,
  parameter logic [31:0] PW_RST      = 32'h0000_00FF,
  localparam int         THR_W       = CNT_W - THR_LSB
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ST_W-1:0]   status_i,
  output ctrl_lo_t          ctrl_o,
  output logic [THR_W-1:0]  thr_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic [PW_W-1:0]   pwidth_o,
  output logic              restart_o,
  output logic              clear_o
);
  logic hit_reload, hit_restart, hit_ctrl, hit_clear, hit_pwidth;
  ctrl_lo_t         ctrl_q;
  logic [THR_W-1:0] thr_q;
  logic [CNT_W-1:0] reload_q;
  logic [PW_W-1:0]  pwidth_q;

  assign hit_reload  = wr_i && (addr_i == ADDR_W'(OFF_RELOAD));
  assign hit_restart = wr_i && (addr_i == ADDR_W'(OFF_RESTART));
  assign hit_ctrl    = wr_i && (addr_i == ADDR_W'(OFF_CTRL));
  assign hit_clear   = wr_i && (addr_i == ADDR_W'(OFF_CLEAR));
  assign hit_pwidth  = wr_i && (addr_i == ADDR_W'(OFF_PWIDTH));

  assign restart_o = hit_restart && (wdata_i == RESTART_KEY);
  assign clear_o   = hit_clear && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      thr_q    <= '0;
      reload_q <= RELOAD_RST[CNT_W-1:0];
      pwidth_q <= PW_RST[PW_W-1:0];
    end else begin
      if (hit_ctrl) begin
        ctrl_q <= ctrl_lo_t'(wdata_i[7:0]);
        thr_q  <= wdata_i[THR_LSB +: THR_W];
      end
      if (hit_reload) reload_q <= wdata_i[CNT_W-1:0];
      if (hit_pwidth) pwidth_q <= wdata_i[PW_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (addr_i == ADDR_W'(OFF_COUNT))  rdata_o = DATA_W'(count_i);
      if (addr_i == ADDR_W'(OFF_RELOAD)) rdata_o = DATA_W'(reload_q);
      if (addr_i == ADDR_W'(OFF_CTRL))
        rdata_o = DATA_W'(ctrl_q) | (DATA_W'(thr_q) << THR_LSB);
      if (addr_i == ADDR_W'(OFF_STATUS)) rdata_o = DATA_W'(status_i);
      if (addr_i == ADDR_W'(OFF_PWIDTH)) rdata_o = DATA_W'(pwidth_q);
    end
  end

  assign ctrl_o   = ctrl_q;
  assign thr_o    = thr_q;
  assign reload_o = reload_q;
  assign pwidth_o = pwidth_q;

  // R10
  idle_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

// File: rtl/keyed_wdt_core.sv
module keyed_wdt_core
  import keyed_wdt_pkg::*;
#(
  parameter int          CNT_W      = 32,
  parameter int          THR_LSB    = 10,
  parameter int          PW_W       = 20,
  parameter logic [31:0] RELOAD_RST = 32'h0100_0000,
  localparam int         THR_W      = CNT_W - THR_LSB
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  ctrl_lo_t         ctrl_i,
  input  logic [THR_W-1:0] thr_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic [PW_W-1:0]  pwidth_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o,
  output logic             pre_hit_o,
  output logic             rst_soc_o,
  output logic             rst_chip_o,
  output logic             rst_cpu_o,
  output logic             ext_pulse_o
);
  logic             step;
  logic [CNT_W-1:0] count_q;
  logic             soc_q, chip_q, cpu_q;
  logic             ext_act_q;
  logic [PW_W-1:0]  ext_cnt_q;
  logic             scope_soc;

  assign step      = ctrl_i.use_tick ? tick_i : 1'b1;
  assign expire_o  = ctrl_i.en && step && (count_q == '0);
  assign pre_hit_o = ctrl_i.irq_en && ctrl_i.en
                     && (count_q[CNT_W-1:THR_LSB] == thr_i);
  assign scope_soc = (ctrl_i.scope == SCOPE_SOC) || (ctrl_i.scope == SCOPE_SOC2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= RELOAD_RST[CNT_W-1:0];
    end else if (restart_i || expire_o) begin
      count_q <= reload_i;
    end else if (ctrl_i.en && step) begin
      count_q <= count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      soc_q  <= 1'b0;
      chip_q <= 1'b0;
      cpu_q  <= 1'b0;
    end else begin
      soc_q  <= expire_o && ctrl_i.rst_en && scope_soc;
      chip_q <= expire_o && ctrl_i.rst_en && (ctrl_i.scope == SCOPE_CHIP);
      cpu_q  <= expire_o && ctrl_i.rst_en && (ctrl_i.scope == SCOPE_CPU);
    end
  end

  // external pulse lasts pwidth+1 steps
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ext_act_q <= 1'b0;
      ext_cnt_q <= '0;
    end else if (expire_o && ctrl_i.ext_en) begin
      ext_act_q <= 1'b1;
      ext_cnt_q <= pwidth_i;
    end else if (ext_act_q && step) begin
      if (ext_cnt_q == '0) ext_act_q <= 1'b0;
      else                 ext_cnt_q <= ext_cnt_q - PW_W'(1);
    end
  end

  assign count_o     = count_q;
  assign rst_soc_o   = soc_q;
  assign rst_chip_o  = chip_q;
  assign rst_cpu_o   = cpu_q;
  assign ext_pulse_o = ext_act_q;

  // R2
  key_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> count_o == $past(reload_i));
  // R3
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_i.en && !restart_i) |=> $stable(count_o));
  // R4
  expire_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> count_o == $past(reload_i));
  // R5
  one_scope_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rst_soc_o, rst_chip_o, rst_cpu_o}));
  // R5
  req_after_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_soc_o || rst_chip_o || rst_cpu_o) |-> $past(expire_o));
endmodule

// File: rtl/keyed_wdt_status.sv
module keyed_wdt_status
  import keyed_wdt_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            expire_i,
  input  logic            boot_sel_i,
  input  logic            pre_hit_i,
  input  logic            clear_i,
  output logic [ST_W-1:0] status_o
);
  logic [ST_W-1:0] status_q, set_bits;

  always_comb begin
    set_bits             = '0;
    set_bits[ST_TIMEOUT] = expire_i;
    set_bits[ST_BOOT]    = expire_i && boot_sel_i;
    set_bits[ST_PRE]     = pre_hit_i;
  end

  // a new event beats a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (clear_i ? '0 : status_q) | set_bits;
  end

  assign status_o = status_q;

  // R8
  clear_wipes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !expire_i && !pre_hit_i) |=> status_o == '0);
  // R6
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_PRE] && !clear_i) |=> status_o[ST_PRE]);
  // R7
  boot_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[ST_BOOT] && !clear_i) |=> status_o[ST_BOOT]);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import keyed_wdt_pkg::*;
#(
  parameter int          ADDR_W      = 8,
  parameter int          CNT_W       = 32,
  parameter int          THR_LSB     = 10,
  parameter int          PW_W        = 20,
  parameter logic [31:0] RESTART_KEY = 32'h0000_4755,
  parameter logic [31:0] RELOAD_RST  = 32'h0100_0000,
  parameter logic [31:0] PW_RST      = 32'h0000_00FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic              rd_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              rst_soc_o,
  output logic              rst_chip_o,
  output logic              rst_cpu_o,
  output logic              ext_pulse_o,
  output logic              boot_alt_o
);
  localparam int THR_W = CNT_W - THR_LSB;

  ctrl_lo_t         ctrl;
  logic [THR_W-1:0] thr;
  logic [CNT_W-1:0] reload, count;
  logic [PW_W-1:0]  pwidth;
  logic             restart, clear, expire, pre_hit;
  logic [ST_W-1:0]  status;

  keyed_wdt_regs #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .THR_LSB(THR_LSB), .PW_W(PW_W),
    .RESTART_KEY(RESTART_KEY), .RELOAD_RST(RELOAD_RST), .PW_RST(PW_RST)
  ) u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .rd_i, .rdata_o,
    .count_i(count), .status_i(status), .ctrl_o(ctrl), .thr_o(thr),
    .reload_o(reload), .pwidth_o(pwidth), .restart_o(restart), .clear_o(clear)
  );

  keyed_wdt_core #(
    .CNT_W(CNT_W), .THR_LSB(THR_LSB), .PW_W(PW_W), .RELOAD_RST(RELOAD_RST)
  ) u_core (
    .clk_i, .rst_ni, .tick_i, .ctrl_i(ctrl), .thr_i(thr), .reload_i(reload),
    .pwidth_i(pwidth), .restart_i(restart), .count_o(count), .expire_o(expire),
    .pre_hit_o(pre_hit), .rst_soc_o, .rst_chip_o, .rst_cpu_o, .ext_pulse_o
  );

  keyed_wdt_status u_status (
    .clk_i, .rst_ni, .expire_i(expire), .boot_sel_i(ctrl.boot_sel),
    .pre_hit_i(pre_hit), .clear_i(clear), .status_o(status)
  );

  assign irq_o      = status[ST_PRE];
  assign boot_alt_o = status[ST_BOOT];
endmodule

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic        rd = 1'b0;
  logic [31:0] rdata;
  logic        irq, r_soc, r_chip, r_cpu, ext, boot;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 0;

  localparam logic [31:0] KEY = 32'h0000_4755;

  always #2 clk = ~clk;

  keyed_watchdog dut_i (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .addr_i(addr), .wr_i(wr),
    .wdata_i(wdata), .rd_i(rd), .rdata_o(rdata), .irq_o(irq),
    .rst_soc_o(r_soc), .rst_chip_o(r_chip), .rst_cpu_o(r_cpu),
    .ext_pulse_o(ext), .boot_alt_o(boot)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic start(input logic [31:0] rl, input logic [31:0] c);
    bus_wr(8'h0C, 32'h0);
    bus_wr(8'h04, rl);
    bus_wr(8'h08, KEY);
    bus_wr(8'h0C, c);
  endtask

  task automatic stop_and_clear();
    bus_wr(8'h0C, 32'h0);
    bus_wr(8'h14, 32'h1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_rd(8'h00, v); chk("R1", "count", v, 32'h0100_0000);
    bus_rd(8'h04, v); chk("R1", "reload", v, 32'h0100_0000);
    bus_rd(8'h0C, v); chk("R1", "ctrl", v, 32'h0);
    bus_rd(8'h10, v); chk("R1", "status", v, 32'h0);
    bus_rd(8'h18, v); chk("R1", "pwidth", v, 32'hFF);
    chk("R1", "outputs", {26'h0, irq, r_soc, r_chip, r_cpu, ext, boot}, 32'h0);
  endtask

  task automatic t_key();
    logic [31:0] v;
    bus_wr(8'h04, 32'd1000);
    bus_wr(8'h08, 32'h0000_4754);
    bus_rd(8'h00, v); chk("R2", "near-miss key", v, 32'h0100_0000);
    bus_wr(8'h08, 32'h0001_4755);
    bus_rd(8'h00, v); chk("R2", "key high bits", v, 32'h0100_0000);
    bus_wr(8'h08, KEY);
    bus_rd(8'h00, v); chk("R2", "key reload", v, 32'd1000);
  endtask

  task automatic t_count();
    logic [31:0] v, w;
    start(32'd1000, 32'h1);
    repeat (20) @(negedge clk);
    bus_rd(8'h00, v); chk("R3", "clock-rate decrement", v, 32'd980);
    bus_wr(8'h0C, 32'h0);
    bus_rd(8'h00, v);
    repeat (10) @(negedge clk);
    bus_rd(8'h00, w); chk("R3", "halted hold", w, v);
    start(32'd1000, 32'h11);
    repeat (5) @(negedge clk);
    bus_rd(8'h00, v); chk("R3", "no tick no step", v, 32'd1000);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      @(negedge clk);
    end
    bus_rd(8'h00, v); chk("R3", "tick steps", v, 32'd995);
    bus_wr(8'h0C, 32'h0);
  endtask

  // reload 5: expiry edge is the 6th after the enabling write
  task automatic t_scope(input logic [1:0] sc, input logic ren, input int which);
    int first = 0, hits = 0;
    logic [2:0] seen = '0;
    logic [31:0] v;
    start(32'd5, 32'h1 | (32'(ren) << 1) | (32'(sc) << 5));
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (r_soc || r_chip || r_cpu) begin
        hits++;
        if (first == 0) first = i;
        seen = seen | {r_soc, r_chip, r_cpu};
      end
    end
    bus_rd(8'h00, v); chk("R4", "count after reload", v, 32'd3);
    bus_rd(8'h10, v); chk("R4", "timeout status", v & 32'h1, 32'h1);
    if (which == 0) begin
      chk("R5", "no request when disabled", 32'(hits), 32'd0);
    end else begin
      chk("R5", "request width", 32'(hits), 32'd1);
      chk("R5", "request cycle", 32'(first), 32'd6);
      chk("R5", "request line", 32'(seen),
          (which == 1) ? 32'h4 : (which == 2) ? 32'h2 : 32'h1);
    end
    stop_and_clear();
  endtask

  task automatic t_boot_clear();
    logic [31:0] v;
    start(32'd5, 32'h81);
    repeat (8) @(negedge clk);
    bus_wr(8'h0C, 32'h0);
    bus_rd(8'h10, v); chk("R7", "boot status", v, 32'h3);
    chk("R7", "boot_alt_o", 32'(boot), 32'h1);
    repeat (4) @(negedge clk);
    chk("R7", "boot sticky", 32'(boot), 32'h1);
    bus_wr(8'h14, 32'h2);
    bus_rd(8'h10, v); chk("R8", "clear bit0 low ignored", v, 32'h3);
    bus_wr(8'h14, 32'h1);
    bus_rd(8'h10, v); chk("R8", "clear", v, 32'h0);
    chk("R8", "boot_alt_o cleared", 32'(boot), 32'h0);
  endtask

  task automatic t_ext();
    int first = 0, hits = 0;
    bus_wr(8'h18, 32'd3);
    start(32'd5, 32'h9);
    for (int i = 1; i <= 11; i++) begin
      @(negedge clk);
      if (ext) begin
        hits++;
        if (first == 0) first = i;
      end
    end
    chk("R9", "pulse length", 32'(hits), 32'd4);
    chk("R9", "pulse start", 32'(first), 32'd6);
    stop_and_clear();
  endtask

  task automatic t_pretimeout();
    logic [31:0] v;
    start(32'h1000, (32'd3 << 10) | 32'h1);
    repeat (4) @(negedge clk);
    chk("R6", "irq off when disabled", 32'(irq), 32'h0);
    start(32'h1000, (32'd3 << 10) | 32'h5);
    @(negedge clk);
    chk("R6", "irq before threshold", 32'(irq), 32'h0);
    @(negedge clk);
    chk("R6", "irq at threshold", 32'(irq), 32'h1);
    bus_wr(8'h0C, 32'h0);
    repeat (5) @(negedge clk);
    chk("R6", "irq sticky", 32'(irq), 32'h1);
    bus_rd(8'h10, v); chk("R6", "status bit2", v, 32'h4);
    bus_wr(8'h14, 32'h1);
    chk("R6", "irq cleared", 32'(irq), 32'h0);
  endtask

  task automatic t_map();
    logic [31:0] v;
    bus_wr(8'h04, 32'hFFFF_FF00);
    bus_wr(8'h08, KEY);
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    bus_rd(8'h0C, v); chk("R10", "ctrl reserved bits", v, 32'hFFFF_FCFF);
    bus_wr(8'h0C, 32'h0);
    bus_wr(8'h14, 32'h1);
    bus_wr(8'h18, 32'hFFFF_FFFF);
    bus_rd(8'h18, v); chk("R10", "pwidth field", v, 32'h000F_FFFF);
    bus_rd(8'h08, v); chk("R10", "restart reads zero", v, 32'h0);
    bus_rd(8'h14, v); chk("R10", "clear reads zero", v, 32'h0);
    bus_rd(8'h1C, v); chk("R10", "unmapped", v, 32'h0);
    addr = 8'h04; rd = 1'b0;
    #1 chk("R10", "no strobe", rdata, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_key();
    t_count();
    t_scope(2'b00, 1'b1, 1);
    t_scope(2'b01, 1'b1, 2);
    t_scope(2'b10, 1'b1, 3);
    t_scope(2'b11, 1'b1, 1);
    t_scope(2'b01, 1'b0, 0);
    t_boot_clear();
    t_ext();
    t_pretimeout();
    t_map();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule